// File: doc/BRIEF.md
# DRAM ECC Error Log

This block records DRAM error events for a two-channel memory controller and makes them visible to software through a small register port. The ECC checker sends it single-bit (correctable) and multi-bit (uncorrectable) error pulses. Each pulse comes with the failing 128-byte line address (physical address bits 32:7), the channel number and the 8-bit syndrome. Three further event pulses report a refresh timeout, a locked access aimed at memory that is not DRAM, and a thermal sensor trip.

Each event sets a sticky flag in a sparse 16-bit status register. Software clears a flag by writing a one to it. A command register selects which flags drive the system-error output. The location and syndrome of one ECC error are held until software has cleared both ECC flags. The one exception is an uncorrectable error, which may replace a logged correctable one.

The register port is simple. A write strobe comes with a 3-bit select and 16-bit write data. Read data is 32 bits and follows the select combinationally.

Top module: `ecc_err_log`

## Requirements
- R1: After reset every register reads zero and `sys_err` is low.
- R2: A pulse sets its sticky status flag on the next clock edge. The flag positions are: bit 0 correctable ECC error, bit 1 uncorrectable ECC error, bit 8 refresh timeout, bit 9 locked non-DRAM access, bit 11 thermal trip. All other status bits read zero.
- R3: A write to the status register (select 0) clears each flag whose write-data bit is 1 and leaves each flag whose bit is 0 unchanged. The clearable mask is 0x0B03.
- R4: The command register (select 1) stores the write data ANDed with 0x0B03, so reserved enable bits read zero.
- R5: `sys_err` is high exactly when some status bit and the command bit at the same position are both 1.
- R6: The address register (select 2) reads the line address bits 31:7 in bits 31:7 and the channel in bit 0, with bits 6:1 zero. The extended register (select 3) reads address bit 32 in bit 0 and zero elsewhere. The syndrome register (select 4) reads the syndrome in bits 7:0.
- R7: An ECC error that arrives while neither ECC flag is held (after any same-cycle clear) captures its address, channel and syndrome.
- R8: An uncorrectable error that arrives while the uncorrectable flag is not held replaces a logged correctable error's address, channel and syndrome. After it, both ECC flags read 1.
- R9: A correctable error that arrives while any ECC flag is held, or an uncorrectable error that arrives while the uncorrectable flag is held, leaves the captured fields unchanged.
- R10: While the correctable flag is still held, clearing only the uncorrectable flag does not re-arm capture for a correctable error. Once both flags are clear, capture is re-armed.
- R11: When a status write and a new event fall in the same cycle, the event's flag ends up set. A clear of both ECC flags in that cycle lets the new ECC error be captured.
- R12: Writes to selects 2, 3, 4 and to unmapped selects 5 to 7 have no effect. Unmapped selects read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_ce_pulse | input | 1 | Correctable ECC error event |
| ecc_ue_pulse | input | 1 | Uncorrectable ECC error event |
| ecc_line_addr | input | 26 | Failing address bits 32:7 |
| ecc_chan | input | 1 | Failing channel |
| ecc_syn | input | 8 | ECC syndrome |
| refresh_timeout | input | 1 | Refresh timeout event |
| lock_nondram | input | 1 | Locked access to non-DRAM memory event |
| thermal_trip | input | 1 | Thermal sensor event |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_sel` |
| sys_err | output | 1 | System-error output from enabled flags |

## Verification
A wrong capture gate would show as an address or syndrome register that changes, or fails to change, on the read port in the cycle after the ECC pulse. The same-cycle clear and event cases are the tightest window. A lost event shows the next cycle as a status flag that reads zero while a command bit is set and `sys_err` stays low. Every step reads back all eight selects and `sys_err` and compares them against a bench model, so any divergence is reported within one cycle of its cause.

// File: rtl/ecc_log_pkg.sv
`timescale 1ns/1ps
package ecc_log_pkg;
    localparam int STAT_W    = 16;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 33;
    localparam int GRAIN_LSB = 7;
    localparam int SYN_W     = 8;
    localparam int SEL_W     = 3;
    localparam int PTR_W     = ADDR_W - GRAIN_LSB;

    localparam int B_CE  = 0;
    localparam int B_UE  = 1;
    localparam int B_RTO = 8;
    localparam int B_LCK = 9;
    localparam int B_THM = 11;

    localparam logic [STAT_W-1:0] FLAG_MASK = 16'h0B03;

    typedef enum logic [SEL_W-1:0] {
        SEL_STATUS = 3'd0,
        SEL_CMD    = 3'd1,
        SEL_ADDR   = 3'd2,
        SEL_XADDR  = 3'd3,
        SEL_SYN    = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic [STAT_W-1:0] flags;
        logic [STAT_W-1:0] enab;
    } stat_regs_t;

    typedef struct packed {
        logic [PTR_W-1:0] line;
        logic             chan;
        logic [SYN_W-1:0] syn;
    } cap_regs_t;
endpackage

// File: rtl/ecc_log_status.sv
`timescale 1ns/1ps
module ecc_log_status
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_ce,
    input  logic              ev_ue,
    input  logic              ev_rto,
    input  logic              ev_lck,
    input  logic              ev_thm,
    input  logic              wr_status,
    input  logic              wr_cmd,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] flags_q,
    output logic [STAT_W-1:0] enab_q,
    output logic [1:0]        ecc_held,
    output logic              sys_err
);
    stat_regs_t        r_d, r_q;
    logic [STAT_W-1:0] clr_bits;
    logic [STAT_W-1:0] kept;
    logic [STAT_W-1:0] set_bits;

    always_comb begin
        clr_bits        = wr_status ? (wdata & FLAG_MASK) : '0;
        kept            = r_q.flags & ~clr_bits;
        set_bits        = '0;
        set_bits[B_CE]  = ev_ce;
        set_bits[B_UE]  = ev_ue;
        set_bits[B_RTO] = ev_rto;
        set_bits[B_LCK] = ev_lck;
        set_bits[B_THM] = ev_thm;
        r_d             = r_q;
        r_d.flags       = kept | set_bits;
        if (wr_cmd) begin
            r_d.enab = wdata & FLAG_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign flags_q  = r_q.flags;
    assign enab_q   = r_q.enab;
    assign ecc_held = {kept[B_UE], kept[B_CE]};
    assign sys_err  = |(r_q.flags & r_q.enab);

    p_ce_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_ce |=> flags_q[B_CE]);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && wdata[B_RTO] && !ev_rto) |=> !flags_q[B_RTO]);

    p_ue_keeps_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ue && flags_q[B_CE] && !(wr_status && wdata[B_CE]))
        |=> (flags_q[B_CE] && flags_q[B_UE]));

    p_event_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && wdata[B_THM] && ev_thm) |=> flags_q[B_THM]);
endmodule

// File: rtl/ecc_log_capture.sv
`timescale 1ns/1ps
module ecc_log_capture
    import ecc_log_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_ce,
    input  logic             ev_ue,
    input  logic [PTR_W-1:0] line,
    input  logic             chan,
    input  logic [SYN_W-1:0] syn,
    input  logic [1:0]       held,
    output logic [PTR_W-1:0] line_q,
    output logic             chan_q,
    output logic [SYN_W-1:0] syn_q
);
    cap_regs_t c_d, c_q;
    logic      take;

    always_comb begin
        // uncorrectable may replace a correctable log; correctable needs an empty log
        take = (ev_ue && !held[1]) || (ev_ce && (held == 2'b00));
        c_d  = c_q;
        if (take) begin
            c_d.line = line;
            c_d.chan = chan;
            c_d.syn  = syn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign line_q = c_q.line;
    assign chan_q = c_q.chan;
    assign syn_q  = c_q.syn;

    p_ue_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ue && !held[1]) |=> (line_q == $past(line) && syn_q == $past(syn)
                                 && chan_q == $past(chan)));

    p_ce_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ce && !ev_ue && held != 2'b00)
        |=> ($stable(line_q) && $stable(chan_q) && $stable(syn_q)));
endmodule

// File: rtl/ecc_log_rdmux.sv
`timescale 1ns/1ps
module ecc_log_rdmux
    import ecc_log_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  logic [STAT_W-1:0] flags,
    input  logic [STAT_W-1:0] enab,
    input  logic [PTR_W-1:0]  line,
    input  logic              chan,
    input  logic [SYN_W-1:0]  syn,
    output logic [DATA_W-1:0] rdata
);
    localparam int LO_W  = DATA_W - GRAIN_LSB;
    localparam int RSV_W = GRAIN_LSB - 1;

    always_comb begin
        case (sel)
            SEL_STATUS: rdata = DATA_W'(flags);
            SEL_CMD:    rdata = DATA_W'(enab);
            SEL_ADDR:   rdata = {line[LO_W-1:0], {RSV_W{1'b0}}, chan};
            SEL_XADDR:  rdata = DATA_W'(line[PTR_W-1:LO_W]);
            SEL_SYN:    rdata = DATA_W'(syn);
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_err_log.sv
`timescale 1ns/1ps
module ecc_err_log
    import ecc_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_ce_pulse,
    input  logic              ecc_ue_pulse,
    input  logic [PTR_W-1:0]  ecc_line_addr,
    input  logic              ecc_chan,
    input  logic [SYN_W-1:0]  ecc_syn,
    input  logic              refresh_timeout,
    input  logic              lock_nondram,
    input  logic              thermal_trip,
    input  logic              reg_wr,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              sys_err
);
    logic              wr_status, wr_cmd;
    logic [STAT_W-1:0] flags, enab;
    logic [1:0]        held;
    logic [PTR_W-1:0]  line_q;
    logic              chan_q;
    logic [SYN_W-1:0]  syn_q;

    assign wr_status = reg_wr && (reg_sel == SEL_STATUS);
    assign wr_cmd    = reg_wr && (reg_sel == SEL_CMD);

    ecc_log_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_ce     (ecc_ce_pulse),
        .ev_ue     (ecc_ue_pulse),
        .ev_rto    (refresh_timeout),
        .ev_lck    (lock_nondram),
        .ev_thm    (thermal_trip),
        .wr_status (wr_status),
        .wr_cmd    (wr_cmd),
        .wdata     (reg_wdata),
        .flags_q   (flags),
        .enab_q    (enab),
        .ecc_held  (held),
        .sys_err   (sys_err)
    );

    ecc_log_capture u_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev_ce  (ecc_ce_pulse),
        .ev_ue  (ecc_ue_pulse),
        .line   (ecc_line_addr),
        .chan   (ecc_chan),
        .syn    (ecc_syn),
        .held   (held),
        .line_q (line_q),
        .chan_q (chan_q),
        .syn_q  (syn_q)
    );

    ecc_log_rdmux u_rdmux (
        .sel   (reg_sel),
        .flags (flags),
        .enab  (enab),
        .line  (line_q),
        .chan  (chan_q),
        .syn   (syn_q),
        .rdata (reg_rdata)
    );

    p_serr_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_timeout && enab[B_RTO] && !(reg_wr && reg_sel == SEL_CMD)) |=> sys_err);
endmodule

// File: tb/sim_ecc_err_log.sv
`timescale 1ns/1ps
module sim_ecc_err_log;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce, ue, ch, rto, lck, thm, wr;
    logic [25:0] line;
    logic [7:0]  syn;
    logic [2:0]  sel;
    logic [15:0] wd;
    logic [31:0] rdata;
    logic        serr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [15:0] m_st, m_en;
    logic [25:0] m_line;
    logic        m_chan;
    logic [7:0]  m_syn;

    always #2.5 clk = ~clk;

    ecc_err_log u0 (
        .clk(clk), .rst_n(rst_n), .ecc_ce_pulse(ce), .ecc_ue_pulse(ue),
        .ecc_line_addr(line), .ecc_chan(ch), .ecc_syn(syn),
        .refresh_timeout(rto), .lock_nondram(lck), .thermal_trip(thm),
        .reg_wr(wr), .reg_sel(sel), .reg_wdata(wd), .reg_rdata(rdata),
        .sys_err(serr)
    );

    function automatic logic [31:0] exp_rd(input logic [2:0] s);
        case (s)
            3'd0:    return {16'h0, m_st};
            3'd1:    return {16'h0, m_en};
            3'd2:    return {m_line[24:0], 6'b0, m_chan};
            3'd3:    return {31'b0, m_line[25]};
            3'd4:    return {24'b0, m_syn};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string def_tag(input int s);
        case (s)
            0:       return "R2 status";
            1:       return "R4 command";
            2:       return "R6 address";
            3:       return "R6 extended";
            4:       return "R6 syndrome";
            default: return "R12 unmapped";
        endcase
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            #0.1;
            cmp((tag == "") ? def_tag(s) : tag, rdata, exp_rd(3'(s)));
        end
        cmp((tag == "") ? "R5 sys_err" : tag, {31'b0, serr}, {31'b0, |(m_st & m_en)});
    endtask

    task automatic model(input bit e_ce, input bit e_ue, input logic [25:0] a,
                         input bit c, input logic [7:0] sy, input bit e_rto,
                         input bit e_lck, input bit e_thm, input bit w,
                         input logic [2:0] s, input logic [15:0] d);
        logic [15:0] clr, kept, setv;
        bit take;
        clr  = (w && s == 3'd0) ? (d & 16'h0B03) : 16'h0;
        kept = m_st & ~clr;
        setv = {4'b0, e_thm, 1'b0, e_lck, e_rto, 6'b0, e_ue, e_ce};
        take = (e_ue && !kept[1]) || (e_ce && kept[1:0] == 2'b00);
        if (take) begin
            m_line = a;
            m_chan = c;
            m_syn  = sy;
        end
        m_st = kept | setv;
        if (w && s == 3'd1) m_en = d & 16'h0B03;
    endtask

    task automatic step(input bit e_ce, input bit e_ue, input logic [25:0] a,
                        input bit c, input logic [7:0] sy, input bit e_rto,
                        input bit e_lck, input bit e_thm, input bit w,
                        input logic [2:0] s, input logic [15:0] d, input string tag);
        ce = e_ce; ue = e_ue; line = a; ch = c; syn = sy;
        rto = e_rto; lck = e_lck; thm = e_thm; wr = w; sel = s; wd = d;
        @(posedge clk);
        model(e_ce, e_ue, a, c, sy, e_rto, e_lck, e_thm, w, s, d);
        @(negedge clk);
        ce = 0; ue = 0; rto = 0; lck = 0; thm = 0; wr = 0;
        check_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; ce = 0; ue = 0; ch = 0; rto = 0; lck = 0; thm = 0; wr = 0;
        line = '0; syn = '0; sel = '0; wd = '0;
        m_st = 0; m_en = 0; m_line = 0; m_chan = 0; m_syn = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check_all("R1 reset state");

        // R7 first correctable error is captured
        step(1, 0, 26'h0ABCDEF, 1, 8'h5A, 0, 0, 0, 0, 0, 0, "R7 first CE capture");
        // R9 second correctable error is ignored
        step(1, 0, 26'h1111111, 0, 8'h11, 0, 0, 0, 0, 0, 0, "R9 CE while held");
        // R8 uncorrectable replaces the logged correctable one
        step(0, 1, 26'h3FFFFFF, 1, 8'hC3, 0, 0, 0, 0, 0, 0, "R8 UE overwrites CE");
        // R9 uncorrectable ignored while uncorrectable held
        step(0, 1, 26'h2222222, 0, 8'h22, 0, 0, 0, 0, 0, 0, "R9 UE while UE held");
        // R3 clear only the multi-bit flag
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'h0002, "R3 clear one flag");
        // R10 correctable not captured while correctable still held
        step(1, 0, 26'h0123456, 0, 8'h33, 0, 0, 0, 0, 0, 0, "R10 CE still blocked");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'h0001, "R3 clear last flag");
        // R10 capture re-armed after both cleared
        step(1, 0, 26'h2000080, 0, 8'h44, 0, 0, 0, 0, 0, 0, "R10 capture re-armed");
        // R11 clear both plus new error in one cycle
        step(0, 1, 26'h1555555, 1, 8'h99, 0, 0, 0, 1, 3'd0, 16'hFFFF, "R11 event beats clear");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 3'd0, 16'h0800, "R11 thermal beats clear");
        // R12 read-only and unmapped writes
        for (int s = 2; s < 8; s++)
            step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'(s), 16'hFFFF, "R12 write ignored");
        // R4 command keeps only mask bits
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 16'hFFFF, "R4 command mask");
        // R5 and R2 other event flags
        step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, "R5 sys_err from refresh/lock");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'h0000, "R3 zero write keeps flags");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 16'hFFFF, "R3 clear all flags");
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 sys_err low when clear");

        for (int i = 0; i < 3000; i++) begin
            logic [15:0] d;
            d = (($urandom % 4) == 0) ? 16'hFFFF : 16'($urandom);
            step(($urandom % 5) == 0, ($urandom % 9) == 0, 26'($urandom), 1'($urandom),
                 8'($urandom), ($urandom % 11) == 0, ($urandom % 13) == 0,
                 ($urandom % 17) == 0, ($urandom % 3) == 0, 3'($urandom), d, "");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule